// File: doc/BRIEF.md
# FSK Frequency-Centering Acquisition Controller

This block decides when a low-IF FSK receiver may move its channel centre and to what value. It watches the demodulated bit stream for an alternating preamble and waits a fixed settling interval. It then captures the demodulator's signed frequency-offset estimate as the applied centre correction. Before capture, the estimate is limited to ±200 kHz.

Once a centre is captured, the block keeps it through gaps in RF activity, so retransmitted packets are received on the same centre from their first bit. Only an uninterrupted quiet period of the hold length releases the centre and restarts the search. A separate enable input forces a zero correction and stops all searching.

All timers count cycles of the 16 MHz reference clock. The settle and hold lengths are parameters, so a test setup can shorten them and keep their ratio. The defaults are 11200 cycles (700 µs) and 3 200 000 cycles (200 ms).

Top module: `fsk_centre_acq`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets ofs_out to 0 and locked to 0.
- R2: At every edge where afc_en is sampled 0, the next outputs are ofs_out = 0 and locked = 0. Bit strobes seen while the block is disabled do not contribute to any later capture.
- R3: While searching with rf_active high, a capture is armed once 2*PAIRS strobed bits in a row alternate in value (PAIRS = 3, so 1,0,1,0,1,0). A strobed bit equal to the one before it restarts the run, and that bit counts as its first member.
- R4: rf_active sampled 0 while searching discards the current alternating run.
- R5: The offset is captured and locked is set exactly SETTLE_CYC edges after the edge that sampled the arming strobe. rf_active sampled 0 during that interval cancels the capture and returns the block to searching.
- R6: The captured offset is ofs_est clamped to ±LIMIT codes. At 125 Hz per code the default LIMIT is 1600, which is 200 kHz. ofs_out never leaves that range.
- R7: While locked stays 1, ofs_out does not change, whatever ofs_est and the bit strobes do.
- R8: After rf_active is sampled 0 while locked, locked stays 1 for HOLD_CYC edges. At the HOLD_CYC-th edge after the one that sampled the drop, locked becomes 0, ofs_out becomes 0 and searching restarts.
- R9: rf_active returning high during the hold keeps the captured centre. The next drop starts a full new hold interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| afc_en | input | 1 | 1 enables centering, 0 forces zero offset |
| rf_active | input | 1 | RF activity indication from the front end |
| bit_stb | input | 1 | One-cycle strobe marking a new demodulated bit |
| bit_val | input | 1 | Demodulated bit value, valid with bit_stb |
| ofs_est | input | 12 | Signed offset estimate, 125 Hz per code |
| ofs_out | output | 12 | Signed applied centre offset, 125 Hz per code |
| locked | output | 1 | A centre is captured and being held |

## Verification
The bench samples locked and ofs_out on the last settle edge before capture and on the capture edge itself, and does the same at the end of the hold. An off-by-one in either timer shows up as a wrong value on one of those two edges. It drops activity briefly during the hold and then checks the full interval after the next drop, which catches a hold timer that is not restarted. A run broken by two equal bits, a run broken by lost activity and a settle cut short must all leave the block unlocked, which catches a pair counter that does not reset. Estimates beyond both limits check the clamp. A disable that arrives while locked and strobes sent while disabled check that the offset is forced to zero and that nothing is counted.

// File: rtl/fsk_centre_acq.sv
module fsk_centre_acq #(
  parameter int EST_W      = 12,
  parameter int LIMIT      = 1600,
  parameter int PAIRS      = 3,
  parameter int SETTLE_CYC = 11200,
  parameter int HOLD_CYC   = 3200000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    afc_en,
  input  logic                    rf_active,
  input  logic                    bit_stb,
  input  logic                    bit_val,
  input  logic signed [EST_W-1:0] ofs_est,
  output logic signed [EST_W-1:0] ofs_out,
  output logic                    locked
);
  localparam int RUN_TGT = 2 * PAIRS;
  localparam int RUN_W   = $clog2(RUN_TGT + 1);
  localparam int TMAX    = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
  localparam int TW      = $clog2(TMAX + 1);
  localparam logic [TW-1:0]    SET_LAST  = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0]    HOLD_LAST = TW'(HOLD_CYC - 1);
  localparam logic [RUN_W-1:0] RUN_DONE  = RUN_W'(RUN_TGT);
  localparam logic signed [EST_W-1:0] HI = EST_W'(LIMIT);
  localparam logic signed [EST_W-1:0] LO = -HI;

  typedef enum logic [2:0] {ST_IDLE, ST_SEARCH, ST_SETTLE, ST_LOCKED, ST_HOLD} st_t;

  st_t              st;
  logic [RUN_W-1:0] run;
  logic             prev;
  logic [TW-1:0]    tmr;

  wire signed [EST_W-1:0] clamped = (ofs_est > HI) ? HI : ((ofs_est < LO) ? LO : ofs_est);
  wire                    alt     = (run != '0) && (bit_val != prev);
  wire [RUN_W-1:0]        run_nx  = alt ? run + 1'b1 : RUN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || !afc_en) begin
      st      <= (rst_n || !afc_en) ? ST_IDLE : ST_SEARCH;
      run     <= '0;
      prev    <= 1'b0;
      tmr     <= '0;
      ofs_out <= '0;
      locked  <= 1'b0;
      if (!rst_n) st <= afc_en ? ST_SEARCH : ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: begin
          st  <= ST_SEARCH;
          run <= '0;
        end
        ST_SEARCH: begin
          if (!rf_active) begin
            run <= '0;
          end else if (bit_stb) begin
            prev <= bit_val;
            if (run_nx == RUN_DONE) begin
              st  <= ST_SETTLE;
              tmr <= '0;
              run <= '0;
            end else begin
              run <= run_nx;
            end
          end
        end
        ST_SETTLE: begin
          if (!rf_active) begin
            st  <= ST_SEARCH;
            run <= '0;
          end else if (tmr == SET_LAST) begin
            ofs_out <= clamped;
            locked  <= 1'b1;
            st      <= ST_LOCKED;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_LOCKED: begin
          if (!rf_active) begin
            st  <= ST_HOLD;
            tmr <= '0;
          end
        end
        ST_HOLD: begin
          if (rf_active) begin
            st <= ST_LOCKED;
          end else if (tmr == HOLD_LAST) begin
            st      <= ST_SEARCH;
            locked  <= 1'b0;
            ofs_out <= '0;
            run     <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= ST_SEARCH;
      endcase
    end
  end

  // R2
  disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !afc_en |=> (ofs_out == '0 && !locked));

  // R6
  ofs_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_out <= HI && ofs_out >= LO));

  // R7
  held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(ofs_out));

  // R9
  active_keeps_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && rf_active && afc_en) |=> locked);

  // R5
  capture_needs_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(rf_active));
endmodule

// File: tb/fsk_centre_acq_tb.sv
module fsk_centre_acq_tb;
  localparam int SETTLE = 40;
  localparam int HOLD   = 100;

  logic clk = 1'b0;
  logic rst_n, afc_en, rf_active, bit_stb, bit_val;
  logic signed [11:0] ofs_est;
  logic signed [11:0] ofs_out;
  logic locked;

  fsk_centre_acq #(.EST_W(12), .LIMIT(1600), .PAIRS(3), .SETTLE_CYC(SETTLE), .HOLD_CYC(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .afc_en(afc_en), .rf_active(rf_active),
    .bit_stb(bit_stb), .bit_val(bit_val), .ofs_est(ofs_est),
    .ofs_out(ofs_out), .locked(locked));

  always #4 clk = ~clk;

  typedef struct {
    int                 cyc;
    logic signed [11:0] o;
    logic               l;
    string              tag;
  } exp_t;

  exp_t q[$];
  exp_t it;
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int last_stb = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      it = q.pop_front();
      checks++;
      if (ofs_out !== it.o || locked !== it.l) begin
        fails++;
        $display("FAIL %s: ofs=%0d locked=%0b expected ofs=%0d locked=%0b",
                 it.tag, ofs_out, locked, it.o, it.l);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) tick(1);
  endtask

  task automatic expect_at(input int c, input logic signed [11:0] o, input logic l, input string tag);
    exp_t e;
    e.cyc = c; e.o = o; e.l = l; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send(input logic b);
    bit_val = b;
    bit_stb = 1'b1;
    tick(1);
    last_stb = cyc;
    bit_stb = 1'b0;
    tick(2);
  endtask

  task automatic preamble(input int n);
    for (int i = 0; i < n; i++) send(i[0] == 1'b0);
  endtask

  initial begin
    int e;
    int c2;
    rst_n = 1'b0; afc_en = 1'b1; rf_active = 1'b0;
    bit_stb = 1'b0; bit_val = 1'b0; ofs_est = '0;
    tick(3);
    expect_at(cyc, 0, 0, "R1 reset state");
    tick(1);
    rst_n = 1'b1;
    tick(2);

    // R3 / R5: normal capture
    rf_active = 1'b1; ofs_est = 300;
    preamble(6);
    e = last_stb;
    expect_at(e + SETTLE - 1, 0, 0, "R5 last settle cycle");
    expect_at(e + SETTLE, 300, 1, "R3 R5 capture edge");
    wait_to(e + SETTLE + 2);

    // R7: held value ignores estimate and strobes
    ofs_est = -900;
    send(1); send(0);
    tick(5);
    expect_at(cyc, 300, 1, "R7 held centre");
    tick(1);

    // R9 / R8: brief gap, then full hold after the next drop
    rf_active = 1'b0;
    tick(50);
    rf_active = 1'b1;
    tick(3);
    expect_at(cyc, 300, 1, "R9 gap keeps centre");
    tick(1);
    c2 = cyc;
    rf_active = 1'b0;
    expect_at(c2 + HOLD, 300, 1, "R9 hold restarted");
    expect_at(c2 + 1 + HOLD, 0, 0, "R8 hold expiry");
    wait_to(c2 + HOLD + 3);

    // R3: equal bits restart the run; R6 upper clamp
    rf_active = 1'b1; ofs_est = 1900;
    send(1); send(0); send(1); send(0); send(1); send(1);
    wait_to(last_stb + SETTLE + 3);
    expect_at(cyc, 0, 0, "R3 equal bits break run");
    tick(1);
    send(0); send(1); send(0); send(1); send(0);
    e = last_stb;
    expect_at(e + SETTLE, 1600, 1, "R6 upper clamp");
    wait_to(e + SETTLE + 2);
    rf_active = 1'b0;
    tick(HOLD + 3);
    expect_at(cyc, 0, 0, "R8 released after quiet period");
    tick(1);

    // R4: activity loss clears the run; R6 lower clamp
    rf_active = 1'b1; ofs_est = -2000;
    preamble(5);
    rf_active = 1'b0;
    tick(1);
    rf_active = 1'b1;
    tick(1);
    send(0);
    wait_to(last_stb + SETTLE + 3);
    expect_at(cyc, 0, 0, "R4 run cleared by inactivity");
    tick(1);
    preamble(5);
    e = last_stb;
    expect_at(e + SETTLE, -1600, 1, "R6 lower clamp");
    wait_to(e + SETTLE + 2);

    // R2: disable while locked, strobes ignored
    c2 = cyc;
    afc_en = 1'b0;
    expect_at(c2 + 1, 0, 0, "R2 disable clears output");
    tick(2);
    preamble(6);
    tick(SETTLE + 3);
    expect_at(cyc, 0, 0, "R2 bits ignored while disabled");
    tick(1);

    // R5: settle cancelled by activity loss
    afc_en = 1'b1;
    tick(3);
    ofs_est = 500;
    preamble(6);
    e = last_stb;
    wait_to(e + 10);
    rf_active = 1'b0;
    tick(1);
    rf_active = 1'b1;
    wait_to(e + SETTLE + 5);
    expect_at(cyc, 0, 0, "R5 settle cancelled");
    tick(1);
    preamble(6);
    e = last_stb;
    expect_at(e + SETTLE, 500, 1, "R5 capture after retry");
    wait_to(e + SETTLE + 3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule